// File: doc/BRIEF.md
# Partitioned Packed SIMD Adder

This block is a 64-bit adder/subtractor whose carry chain can be cut into independent sub-word lanes. A two-bit lane-size input selects one of four partitionings: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane adds or subtracts its slice of the two operands at the same time and wraps on its own width. No carry or borrow crosses from one lane into the next.

For each lane the block also reports signed (two's complement) overflow. The overflow vector has one bit per byte position. A lane's flag sits in the bit of its most significant byte, and all other bits are zero. Subtraction uses one shared datapath: B is inverted and a carry-in of 1 enters the bottom of every lane. With the default parameter the results pass through one output register, which is cleared by a synchronous reset. With REG_OUT set to 0 the block is purely combinational.

Top module: `psimd_adder`

## Requirements
- R1: `mode_i` selects the lane size: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives one 64-bit lane. Lane k occupies bits [k*w +: w], with lane 0 in the least significant bits.
- R2: With `sub_i`=0, each lane of `sum_o` equals (A lane + B lane) mod 2^w.
- R3: No carry crosses a lane boundary. A carry out of a lane's top bit is discarded and never changes the next lane.
- R4: With `sub_i`=1, each lane of `sum_o` equals (A lane − B lane) mod 2^w.
- R5: `ovf_o` is 8 bits wide. The flag of lane k is at bit (k+1)*(w/8)−1. Every other bit is 0, so 64-bit mode can only set bit 7, and 32-bit mode can only set bits 3 and 7.
- R6: In add mode, a lane flag is 1 exactly when both operand lanes have the same sign bit and the result lane's sign bit differs from it.
- R7: In subtract mode, a lane flag is 1 exactly when the operand lanes have different sign bits and the result lane's sign bit differs from A's.
- R8: With REG_OUT=1 (the default), `sum_o` and `ovf_o` show the result of the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, both outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Lane-size select (encoding in R1) |
| sub_i | input | 1 | 0 = add, 1 = subtract B from A |
| a_i | input | 64 | Packed operand A |
| b_i | input | 64 | Packed operand B |
| sum_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-lane signed overflow, one bit per byte position |

## Verification
The assertions check several properties on every cycle: the isolation of one byte lane from its neighbour in 8-bit mode, the full-width result in 64-bit mode, the identity A−0=A in every mode, the zero overflow bits that 32-bit and 64-bit modes require, and the one-cycle registered latency. Only the bench's scenarios can show the rest. These are the exact overflow positions for lanes that saturate their sign bit, wrap-around with the carry discarded at every boundary, borrow behaviour across lanes when subtracting, and the clearing of the outputs by reset while the inputs are active. The scoreboard compares every result against a lane-by-lane reference model.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    localparam int DATA_W   = 64;
    localparam int SLICE_W  = 8;
    localparam int N_SLICE  = DATA_W / SLICE_W;

    // Lane size selection; the value is log2 of the slices per lane.
    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_H16 = 2'b01,
        LANE_W32 = 2'b10,
        LANE_Q64 = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]  sum;
        logic [N_SLICE-1:0] ovf;
    } psimd_res_t;

    // Bit i set when the top of slice i is also the top of a lane.
    function automatic logic [N_SLICE-1:0] lane_tops(lane_mode_e m);
        logic [N_SLICE-1:0] t;
        int unsigned        per_lane;
        per_lane = 1 << int'(m);
        for (int i = 0; i < N_SLICE; i++) begin
            t[i] = (((i + 1) % per_lane) == 0);
        end
        return t;
    endfunction

endpackage

// File: rtl/lane_cut_ctrl.sv
module lane_cut_ctrl
    import psimd_pkg::*;
#(
    parameter int NSL = N_SLICE
) (
    input  lane_mode_e       mode,
    output logic [NSL-2:0]   cut,
    output logic [NSL-1:0]   top
);
    logic [N_SLICE-1:0] tops_full;

    always_comb begin
        tops_full = lane_tops(mode);
        top       = tops_full[NSL-1:0];
        // A slice boundary is a lane boundary wherever the lower slice tops a lane.
        cut       = tops_full[NSL-2:0];
    end
endmodule

// File: rtl/slice_chain.sv
module slice_chain
    import psimd_pkg::*;
#(
    parameter int SW  = SLICE_W,
    parameter int NSL = N_SLICE
) (
    input  logic [SW*NSL-1:0] a,
    input  logic [SW*NSL-1:0] b,
    input  logic              sub,
    input  logic [NSL-2:0]    cut,
    output logic [SW*NSL-1:0] sum,
    output logic [NSL-1:0]    raw_ovf
);
    for (genvar i = 0; i < NSL; i++) begin : g_slice
        logic [SW-1:0] a_s;
        logic [SW-1:0] bx_s;
        logic [SW-1:0] s_s;
        logic          c_in;
        logic          c_out;

        assign a_s  = a[i*SW +: SW];
        assign bx_s = sub ? ~b[i*SW +: SW] : b[i*SW +: SW];

        if (i == 0) begin : g_first
            assign c_in = sub;
        end else begin : g_next
            // At a lane boundary the slice restarts with the lane carry-in.
            assign c_in = cut[i-1] ? sub : g_slice[i-1].c_out;
        end

        assign {c_out, s_s}      = {1'b0, a_s} + {1'b0, bx_s} + {{SW{1'b0}}, c_in};
        assign sum[i*SW +: SW]   = s_s;
        assign raw_ovf[i]        = (a_s[SW-1] == bx_s[SW-1]) && (s_s[SW-1] != a_s[SW-1]);
    end
endmodule

// File: rtl/ovf_gather.sv
module ovf_gather #(
    parameter int NSL = 8
) (
    input  logic [NSL-1:0] raw,
    input  logic [NSL-1:0] top,
    output logic [NSL-1:0] flags
);
    always_comb begin
        for (int i = 0; i < NSL; i++) begin
            flags[i] = raw[i] & top[i];
        end
    end
endmodule

// File: rtl/psimd_adder.sv
module psimd_adder
    import psimd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_i,
    input  logic               sub_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    output logic [DATA_W-1:0]  sum_o,
    output logic [N_SLICE-1:0] ovf_o
);
    lane_mode_e         mode;
    logic [N_SLICE-2:0] cut;
    logic [N_SLICE-1:0] top;
    logic [N_SLICE-1:0] raw_ovf;
    psimd_res_t         res_c;

    assign mode = lane_mode_e'(mode_i);

    lane_cut_ctrl #(.NSL(N_SLICE)) cut_i (
        .mode (mode),
        .cut  (cut),
        .top  (top)
    );

    slice_chain #(.SW(SLICE_W), .NSL(N_SLICE)) chain_i (
        .a       (a_i),
        .b       (b_i),
        .sub     (sub_i),
        .cut     (cut),
        .sum     (res_c.sum),
        .raw_ovf (raw_ovf)
    );

    ovf_gather #(.NSL(N_SLICE)) gather_i (
        .raw   (raw_ovf),
        .top   (top),
        .flags (res_c.ovf)
    );

    if (REG_OUT) begin : g_reg
        psimd_res_t res_q;
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res_c;
        end
        assign sum_o = res_q.sum;
        assign ovf_o = res_q.ovf;

        // R8
        reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (sum_o == $past(res_c.sum)) && (ovf_o == $past(res_c.ovf)));
    end else begin : g_comb
        assign sum_o = res_c.sum;
        assign ovf_o = res_c.ovf;
    end

    // R3
    byte_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LANE_B8) |->
        res_c.sum[15:8] == (sub_i ? (a_i[15:8] - b_i[15:8]) : (a_i[15:8] + b_i[15:8])));

    // R2
    quad_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LANE_Q64 && !sub_i) |-> res_c.sum == a_i + b_i);

    // R4
    sub_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_i && b_i == '0) |-> (res_c.sum == a_i) && (res_c.ovf == '0));

    // R5
    wide_ovf_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LANE_W32 || mode == LANE_Q64) |->
        ({res_c.ovf[6:4], res_c.ovf[2:0]} == 6'b0) &&
        (mode != LANE_Q64 || res_c.ovf[3] == 1'b0));
endmodule

// File: tb/psimd_adder_tb_top.sv
module psimd_adder_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'b00;
    logic        sub_i = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [63:0] sum_o;
    logic [7:0]  ovf_o;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [63:0] sum;
        logic [7:0]  ovf;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    psimd_adder dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .sub_i(sub_i),
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .ovf_o(ovf_o)
    );

    // Reference model built from R1, R2, R4-R7.
    function automatic exp_t model(logic [1:0] m, logic s, logic [63:0] a,
                                   logic [63:0] b, string tag);
        exp_t        e;
        int          w;
        int          lanes;
        logic [63:0] mask;
        e.sum = '0;
        e.ovf = '0;
        e.tag = tag;
        w     = 8 << m;
        lanes = 8 >> m;
        mask  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < lanes; l++) begin
            logic [63:0] av, bv, rv;
            logic sa, sb, sr;
            av = (a >> (l * w)) & mask;
            bv = (b >> (l * w)) & mask;
            rv = (s ? (av - bv) : (av + bv)) & mask;
            sa = av[w-1];
            sb = bv[w-1];
            sr = rv[w-1];
            e.sum |= rv << (l * w);
            if (s ? (sa != sb && sr != sa) : (sa == sb && sr != sa))
                e.ovf[(l + 1) * (w / 8) - 1] = 1'b1;
        end
        return e;
    endfunction

    task automatic drive(logic [1:0] m, logic s, logic [63:0] a, logic [63:0] b,
                         string tag);
        @(negedge clk);
        mode_i = m;
        sub_i  = s;
        a_i    = a;
        b_i    = b;
        sb_q.push_back(model(m, s, a, b, tag));
    endtask

    // Monitor: the registered result is visible just after the capturing edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (sum_o !== e.sum || ovf_o !== e.ovf) begin
                n_bad++;
                $display("FAIL %s: sum act %h exp %h, ovf act %b exp %b",
                         e.tag, sum_o, e.sum, ovf_o, e.ovf);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R8: reset clears outputs while inputs are active.
        a_i = '1;
        b_i = 64'h0101010101010101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_vec++;
        if (sum_o !== '0 || ovf_o !== '0) begin
            n_bad++;
            $display("FAIL R8 reset: sum act %h exp 0, ovf act %b exp 0", sum_o, ovf_o);
        end

        // R1 R2 R6: 8-bit lanes hitting signed overflow everywhere.
        drive(2'b00, 1'b0, 64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, "R6 byte ovf");
        // R3: every byte carries out, none may leak.
        drive(2'b00, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, "R3 byte carry cut");
        drive(2'b01, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0001000100010001, "R3 word carry cut");
        drive(2'b10, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000100000001, "R3 dword carry cut");
        drive(2'b11, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, "R2 quad wrap");
        // R2: carry inside a 16-bit lane must propagate.
        drive(2'b01, 1'b0, 64'h00FF00FF00FF00FF, 64'h0001000100010001, "R2 word inner carry");
        // R5: flag positions per width.
        drive(2'b01, 1'b0, 64'h7FFF7FFF7FFF7FFF, 64'h0001000100010001, "R5 word flags");
        drive(2'b10, 1'b0, 64'h7FFFFFFF7FFFFFFF, 64'h0000000100000001, "R5 dword flags");
        drive(2'b11, 1'b0, 64'h7FFFFFFFFFFFFFFF, 64'h0000000000000001, "R5 quad flag");
        drive(2'b00, 1'b0, 64'h8080808080808080, 64'h8080808080808080, "R6 neg+neg");
        // R4: borrow stays in its lane.
        drive(2'b00, 1'b1, 64'h0000000000000000, 64'h0101010101010101, "R4 byte borrow");
        drive(2'b10, 1'b1, 64'h0000000000000000, 64'h0000000100000001, "R4 dword borrow");
        drive(2'b11, 1'b1, 64'h0000000000000000, 64'h0000000000000001, "R4 quad borrow");
        // R7: subtract overflow.
        drive(2'b00, 1'b1, 64'h8080808080808080, 64'h0101010101010101, "R7 byte sub ovf");
        drive(2'b01, 1'b1, 64'h7FFF00007FFF0000, 64'hFFFF0001FFFF0001, "R7 word sub ovf");
        // Mixed random traffic across all modes and both operations.
        for (int i = 0; i < 400; i++) begin
            drive(2'(i % 4), 1'((i / 4) % 2), {$urandom, $urandom}, {$urandom, $urandom},
                  "R2 R4 R6 R7 random");
        end
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule